// File: doc/BRIEF.md
# Page Buffer Bit-Flip Corrector

This block repairs single bits held in a page buffer once an upstream root-search stage has located them. Each located error arrives as a chunk number and a bit offset inside that chunk. The block turns the pair into a buffer column (word) address and a 32-bit flip mask. It reads the addressed word, inverts the flagged bits and writes the word back to the same column. The correction happens in place in the buffer. Data is never corrected as it streams past.

Positions enter through a valid/ready handshake into a small internal queue. The corrector runs one read-modify-write at a time. Positions that arrive back to back and land in the same word are folded into one mask, so the word gets a single read and a single write. The last position of a correction phase carries a flag. When that position's write has completed and the queue is empty, the block raises a one-cycle done pulse and returns to idle. The chunk under correction is reported on its own port, so a downstream decoder can work on the next chunk while repairs to this one finish.

Top module: `bit_fix_rmw`

## Requirements
- R1: After a synchronous active-high reset, busy, done and both buffer strobes are low and pos_ready is high.
- R2: A position (chunk c, offset b) addresses column c*(CHUNK_BITS/32) + floor(b/32). The bit inverted inside that word is b mod 32, where bit 0 is the least significant bit of the data bus.
- R3: Each correction drives the read strobe for one cycle and the write strobe exactly two cycles later, to the same column. The read strobe and the write strobe are never high in the same cycle.
- R4: The word written back equals the word read with the flagged bits inverted. Every other bit of the buffer is left unchanged.
- R5: Positions accepted in consecutive cycles that fall in the same column are merged into one read and one write. A bit named twice within one merged group is inverted once.
- R6: Positions in different columns are corrected in the order they were accepted, with one read-modify-write per group.
- R7: done is high for exactly one cycle, in the cycle after the write of the group that holds the last-flagged position, when the queue is empty. busy is low in the following cycle.
- R8: While no positions are pending, the block stays idle: busy is low and it issues no buffer strobes.
- R9: During each write, fix_chunk equals the chunk that owns the column being written.
- R10: pos_ready falls while the queue is full. Every position offered is eventually corrected and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_valid | input | 1 | Error position offered |
| pos_ready | output | 1 | Queue can take a position |
| pos_chunk | input | $clog2(N_CHUNKS) | Chunk holding the error |
| pos_ofs | input | $clog2(CHUNK_BITS) | Bit offset inside the chunk |
| pos_last | input | 1 | Final position of this correction phase |
| buf_rd_en | output | 1 | Buffer read strobe (buffer to corrector) |
| buf_wr_en | output | 1 | Buffer write strobe (corrector to buffer) |
| buf_col | output | COL_W | Buffer column address |
| buf_rdata | input | 32 | Read data, valid the cycle after the read strobe |
| buf_wdata | output | 32 | Corrected write data |
| fix_chunk | output | $clog2(N_CHUNKS) | Chunk currently being corrected |
| busy | output | 1 | A correction is in progress |
| done | output | 1 | One-cycle end-of-phase pulse |

## Verification
The bench builds the block with four chunks of 256 bits each, which gives 8 words per chunk and 32 columns, and with a queue depth of 4. The small column space means random positions clustered on a few words keep hitting the same column, which exercises merging. Batches of twelve positions overrun the four-entry queue, so back-pressure occurs in every random batch. Directed cases cover the first and last column, duplicate bits, out-of-order columns and the idle period after done.

// File: rtl/bfix_pkg.sv
package bfix_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = $clog2(WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MERGE = 3'd1,
        ST_READ  = 3'd2,
        ST_CAPT  = 3'd3,
        ST_WRITE = 3'd4
    } rmw_state_e;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANE_W-1:0] lane);
        return WORD_W'(1) << lane;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/bfix_queue.sv
module bfix_queue #(
    parameter int ENTRY_W = 12,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic [ENTRY_W-1:0] din,
    input  logic               pop,
    output logic [ENTRY_W-1:0] dout,
    output logic               empty,
    output logic               full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign dout  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + CNT_W'(1);
            end else if (pop && !push) begin
                count <= count - CNT_W'(1);
            end
        end
    end

    AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R10
    AST_QUEUE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R6

endmodule

// File: rtl/bfix_locate.sv
module bfix_locate
    import bfix_pkg::*;
#(
    parameter int N_CHUNKS   = 8,
    parameter int CHUNK_BITS = 1024,
    parameter int CHUNK_W    = $clog2(N_CHUNKS),
    parameter int OFS_W      = $clog2(CHUNK_BITS),
    parameter int COL_W      = $clog2(N_CHUNKS * (CHUNK_BITS / WORD_W))
) (
    input  logic [CHUNK_W-1:0] chunk,
    input  logic [OFS_W-1:0]   ofs,
    output logic [COL_W-1:0]   col,
    output logic [WORD_W-1:0]  mask
);
    localparam int WPC    = CHUNK_BITS / WORD_W;
    localparam int WIDX_W = OFS_W - LANE_W;

    logic [WIDX_W-1:0] word_idx;
    logic [LANE_W-1:0] lane;

    assign word_idx = ofs[OFS_W-1:LANE_W];
    assign lane     = ofs[LANE_W-1:0];
    assign mask     = lane_mask(lane);

    generate
        if (is_pow2(N_CHUNKS) && is_pow2(WPC) && (CHUNK_W + WIDX_W == COL_W)) begin : g_concat
            assign col = {chunk, word_idx};
        end else begin : g_mul
            assign col = COL_W'(chunk) * COL_W'(WPC) + COL_W'(word_idx);
        end
    endgenerate

endmodule

// File: rtl/bfix_rmw_fsm.sv
module bfix_rmw_fsm
    import bfix_pkg::*;
#(
    parameter int CHUNK_W = 3,
    parameter int COL_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               q_empty,
    input  logic [COL_W-1:0]   head_col,
    input  logic [WORD_W-1:0]  head_mask,
    input  logic [CHUNK_W-1:0] head_chunk,
    input  logic               head_last,
    output logic               q_pop,
    output logic               buf_rd_en,
    output logic               buf_wr_en,
    output logic [COL_W-1:0]   buf_col,
    input  logic [WORD_W-1:0]  buf_rdata,
    output logic [WORD_W-1:0]  buf_wdata,
    output logic [CHUNK_W-1:0] fix_chunk,
    output logic               busy,
    output logic               done
);
    rmw_state_e         state, state_nx;
    logic [COL_W-1:0]   col_q;
    logic [WORD_W-1:0]  mask_q;
    logic [WORD_W-1:0]  data_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic               last_q;
    logic               done_q;
    logic               load_new;
    logic               merge_in;

    always_comb begin
        state_nx = state;
        load_new = 1'b0;
        merge_in = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!q_empty) begin
                    load_new = 1'b1;
                    state_nx = ST_MERGE;
                end
            end
            ST_MERGE: begin
                if (!q_empty && head_col == col_q) begin
                    merge_in = 1'b1;
                end else begin
                    state_nx = ST_READ;
                end
            end
            ST_READ:  state_nx = ST_CAPT;
            ST_CAPT:  state_nx = ST_WRITE;
            ST_WRITE: begin
                if (!q_empty) begin
                    load_new = 1'b1;
                    state_nx = ST_MERGE;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign q_pop = load_new || merge_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            col_q   <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            chunk_q <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= (state == ST_WRITE) && q_empty && last_q;
            if (load_new) begin
                col_q   <= head_col;
                mask_q  <= head_mask;
                chunk_q <= head_chunk;
                last_q  <= (state == ST_WRITE) ? (last_q | head_last) : head_last;
            end else if (merge_in) begin
                mask_q <= mask_q | head_mask;
                last_q <= last_q | head_last;
            end else if (state == ST_WRITE) begin
                last_q <= 1'b0;
            end
            if (state == ST_CAPT) begin
                data_q <= buf_rdata;
            end
        end
    end

    assign buf_rd_en = (state == ST_READ);
    assign buf_wr_en = (state == ST_WRITE);
    assign buf_col   = col_q;
    assign buf_wdata = data_q ^ mask_q;
    assign fix_chunk = chunk_q;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(buf_rd_en && buf_wr_en));  // R3
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> $past(buf_rd_en, 2));  // R3
    AST_WRITE_SAME_COL: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> buf_col == $past(buf_col, 2));  // R3
    AST_WRITE_CHANGES_WORD: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> buf_wdata != $past(buf_rdata));  // R4
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(buf_wr_en));  // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R7
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !buf_rd_en && !buf_wr_en);  // R8
    AST_CHUNK_HELD: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> $stable(fix_chunk));  // R9

endmodule

// File: rtl/bit_fix_rmw.sv
module bit_fix_rmw
    import bfix_pkg::*;
#(
    parameter int N_CHUNKS    = 8,
    parameter int CHUNK_BITS  = 1024,
    parameter int QUEUE_DEPTH = 8,
    parameter int CHUNK_W     = $clog2(N_CHUNKS),
    parameter int OFS_W       = $clog2(CHUNK_BITS),
    parameter int COL_W       = $clog2(N_CHUNKS * (CHUNK_BITS / 32))
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pos_valid,
    output logic               pos_ready,
    input  logic [CHUNK_W-1:0] pos_chunk,
    input  logic [OFS_W-1:0]   pos_ofs,
    input  logic               pos_last,
    output logic               buf_rd_en,
    output logic               buf_wr_en,
    output logic [COL_W-1:0]   buf_col,
    input  logic [31:0]        buf_rdata,
    output logic [31:0]        buf_wdata,
    output logic [CHUNK_W-1:0] fix_chunk,
    output logic               busy,
    output logic               done
);
    localparam int ENTRY_W = CHUNK_W + OFS_W + 1;

    logic               q_push, q_pop, q_empty, q_full;
    logic [ENTRY_W-1:0] q_din, q_dout;
    logic [CHUNK_W-1:0] head_chunk;
    logic [OFS_W-1:0]   head_ofs;
    logic               head_last;
    logic [COL_W-1:0]   head_col;
    logic [WORD_W-1:0]  head_mask;

    assign pos_ready = !q_full;
    assign q_push    = pos_valid && pos_ready;
    assign q_din     = {pos_chunk, pos_ofs, pos_last};
    assign {head_chunk, head_ofs, head_last} = q_dout;

    bfix_queue #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (QUEUE_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (q_din),
        .pop   (q_pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    bfix_locate #(
        .N_CHUNKS   (N_CHUNKS),
        .CHUNK_BITS (CHUNK_BITS),
        .CHUNK_W    (CHUNK_W),
        .OFS_W      (OFS_W),
        .COL_W      (COL_W)
    ) u_locate (
        .chunk (head_chunk),
        .ofs   (head_ofs),
        .col   (head_col),
        .mask  (head_mask)
    );

    bfix_rmw_fsm #(
        .CHUNK_W (CHUNK_W),
        .COL_W   (COL_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .q_empty    (q_empty),
        .head_col   (head_col),
        .head_mask  (head_mask),
        .head_chunk (head_chunk),
        .head_last  (head_last),
        .q_pop      (q_pop),
        .buf_rd_en  (buf_rd_en),
        .buf_wr_en  (buf_wr_en),
        .buf_col    (buf_col),
        .buf_rdata  (buf_rdata),
        .buf_wdata  (buf_wdata),
        .fix_chunk  (fix_chunk),
        .busy       (busy),
        .done       (done)
    );

    AST_READY_WHEN_ROOM: assert property (@(posedge clk) disable iff (rst)
        !pos_ready |-> busy);  // R10

endmodule

// File: tb/bit_fix_rmw_test.sv
module bit_fix_rmw_test;
    localparam int NC   = 4;
    localparam int CB   = 256;
    localparam int QD   = 4;
    localparam int WPC  = CB / 32;
    localparam int NW   = NC * WPC;
    localparam int CW   = $clog2(NC);
    localparam int OW   = $clog2(CB);
    localparam int COLW = $clog2(NW);

    logic            clk = 1'b0;
    logic            rst;
    logic            pos_valid, pos_ready, pos_last;
    logic [CW-1:0]   pos_chunk;
    logic [OW-1:0]   pos_ofs;
    logic            buf_rd_en, buf_wr_en;
    logic [COLW-1:0] buf_col;
    logic [31:0]     buf_rdata, buf_wdata;
    logic [CW-1:0]   fix_chunk;
    logic            busy, done;

    always #10 clk = ~clk;

    bit_fix_rmw #(.N_CHUNKS(NC), .CHUNK_BITS(CB), .QUEUE_DEPTH(QD)) uut (
        .clk(clk), .rst(rst), .pos_valid(pos_valid), .pos_ready(pos_ready),
        .pos_chunk(pos_chunk), .pos_ofs(pos_ofs), .pos_last(pos_last),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_col(buf_col),
        .buf_rdata(buf_rdata), .buf_wdata(buf_wdata), .fix_chunk(fix_chunk),
        .busy(busy), .done(done)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int rd_cyc, last_wr_cyc, wr_cnt, rd_cnt, done_cnt, stall_cnt;
    logic [COLW-1:0] rd_col;
    logic [COLW-1:0] wr_log [16];
    logic [31:0] mem     [NW];
    logic [31:0] ref_mem [NW];
    logic [CW-1:0] bc [64];
    logic [OW-1:0] bo [64];
    int bn;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", rq, act, exp, $time);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // buffer model and strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pos_valid && !pos_ready) stall_cnt++;
            if (buf_rd_en && buf_wr_en) chk(1'b0, "R3 strobes overlap", 1, 0);
            if (buf_rd_en) begin
                buf_rdata = mem[buf_col];
                rd_cyc = cyc;
                rd_col = buf_col;
                rd_cnt++;
            end
            if (buf_wr_en) begin
                mem[buf_col] = buf_wdata;
                if (wr_cnt < 16) wr_log[wr_cnt] = buf_col;
                wr_cnt++;
                chk(cyc == rd_cyc + 2, "R3 write cycle", cyc, rd_cyc + 2);
                chk(buf_col == rd_col, "R3 write column", buf_col, rd_col);
                chk(int'(fix_chunk) == int'(buf_col) / WPC, "R9 fix_chunk", fix_chunk, int'(buf_col) / WPC);
                last_wr_cyc = cyc;
            end
            if (done) begin
                done_cnt++;
                chk(cyc == last_wr_cyc + 1, "R7 done timing", cyc, last_wr_cyc + 1);
            end
        end
    end

    function automatic int col_of(input int c, input int o);
        return c * WPC + o / 32;
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < NW; i++) begin
            mem[i] = $urandom;
            ref_mem[i] = mem[i];
        end
    endtask

    // Pushes bc/bo[0..bn-1] back to back, waits for done, checks buffer content
    task automatic run_batch(input string rq);
        logic [31:0] orm [NW];
        int bad, first_bad, t;
        for (int i = 0; i < NW; i++) orm[i] = '0;
        for (int i = 0; i < bn; i++) orm[col_of(int'(bc[i]), int'(bo[i]))][bo[i] % 32] = 1'b1;
        for (int i = 0; i < NW; i++) ref_mem[i] = ref_mem[i] ^ orm[i];
        wr_cnt = 0; rd_cnt = 0; done_cnt = 0;
        for (int i = 0; i < bn; i++) begin
            pos_valid = 1'b1;
            pos_chunk = bc[i];
            pos_ofs   = bo[i];
            pos_last  = (i == bn - 1);
            while (!pos_ready) @(negedge clk);
            @(negedge clk);
        end
        pos_valid = 1'b0;
        pos_last  = 1'b0;
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, {rq, " R7 done seen"}, done, 1);
        @(negedge clk);
        chk(busy == 1'b0, {rq, " R7 idle after done"}, busy, 0);
        repeat (2) @(negedge clk);
        chk(done_cnt == 1, {rq, " R7 single done"}, done_cnt, 1);
        bad = 0; first_bad = -1;
        for (int i = 0; i < NW; i++) begin
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad < 0) chk(1'b1, {rq, " R4 buffer"}, 0, 0);
        else chk(1'b0, {rq, " R4 buffer word"}, mem[first_bad], ref_mem[first_bad]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int sel [3];
        logic [NW*32-1:0] used;
        int idle_strobes;
        void'($urandom(32'd20240611));
        rst = 1'b1; pos_valid = 1'b0; pos_chunk = '0; pos_ofs = '0; pos_last = 1'b0;
        buf_rdata = '0; stall_cnt = 0; wr_cnt = 0; rd_cnt = 0; done_cnt = 0;
        rd_cyc = 0; last_wr_cyc = 0; rd_col = '0;
        fill_mem();
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(buf_rd_en == 1'b0 && buf_wr_en == 1'b0, "R1 strobes", {buf_rd_en, buf_wr_en}, 0);
        chk(pos_ready == 1'b1, "R1 ready", pos_ready, 1);
        rst = 1'b0;
        @(negedge clk);

        // R2 first column, bit 0
        bn = 1; bc[0] = 0; bo[0] = 0;
        run_batch("first");
        chk(wr_cnt == 1 && wr_log[0] == 0, "R2 column 0", wr_log[0], 0);
        // R2 last column, bit 31
        bn = 1; bc[0] = CW'(NC - 1); bo[0] = OW'(CB - 1);
        run_batch("last");
        chk(wr_log[0] == COLW'(NW - 1), "R2 last column", wr_log[0], NW - 1);
        // R2 middle: chunk 1 offset 37 -> column 9 lane 5
        bn = 1; bc[0] = 1; bo[0] = 37;
        run_batch("mid");
        chk(wr_log[0] == 9, "R2 column 9", wr_log[0], 9);

        // R5 merge three positions in one word
        bn = 3; bc[0] = 2; bo[0] = 64; bc[1] = 2; bo[1] = 70; bc[2] = 2; bo[2] = 95;
        run_batch("merge");
        chk(wr_cnt == 1 && rd_cnt == 1, "R5 single RMW", wr_cnt, 1);
        chk(wr_log[0] == 18, "R5 merged column", wr_log[0], 18);
        // R5 duplicate bit inverted once
        bn = 2; bc[0] = 0; bo[0] = 10; bc[1] = 0; bo[1] = 10;
        run_batch("dup");
        chk(wr_cnt == 1, "R5 duplicate one write", wr_cnt, 1);

        // R6 acceptance order across columns
        bn = 2; bc[0] = 1; bo[0] = 40; bc[1] = 0; bo[1] = 200;
        run_batch("order");
        chk(wr_cnt == 2, "R6 two writes", wr_cnt, 2);
        chk(wr_log[0] == 9 && wr_log[1] == 6, "R6 order", {wr_log[0], wr_log[1]}, {5'd9, 5'd6});

        // R8 quiet while nothing pending
        idle_strobes = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (buf_rd_en || buf_wr_en || busy) idle_strobes++;
        end
        chk(idle_strobes == 0, "R8 idle quiet", idle_strobes, 0);

        // Random batches clustered on three words; R10 back-pressure
        for (int b = 0; b < 10; b++) begin
            fill_mem();
            used = '0;
            for (int k = 0; k < 3; k++) sel[k] = $urandom_range(0, NW - 1);
            bn = 12;
            for (int i = 0; i < bn; i++) begin
                int col, lane;
                do begin
                    col  = sel[$urandom_range(0, 2)];
                    lane = $urandom_range(0, 31);
                end while (used[col * 32 + lane]);
                used[col * 32 + lane] = 1'b1;
                bc[i] = CW'(col / WPC);
                bo[i] = OW'((col % WPC) * 32 + lane);
            end
            stall_cnt = 0;
            run_batch("random R10");
            chk(wr_cnt >= 1 && wr_cnt <= 12, "R6 write count", wr_cnt, 12);
            chk(stall_cnt > 0, "R10 backpressure seen", stall_cnt, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule